// File: doc/BRIEF.md
# Multi-Channel Ten-to-One Serializer with Phase-Locked Load

The block converts parallel words into serial bit streams. Each channel takes a `WIDTH`-bit word (ten bits by default) produced by logic in a slow clock domain. It sends that word out on one serial output, clocked by a fast clock that runs at `WIDTH` times the slow rate. The two clocks come from outside the block. Their rising edges are assumed to coincide once per slow period.

On each slow rising edge, every channel copies its input word into a holding register. A phase counter in the fast domain, shared by all channels, counts fast edges modulo `WIDTH`. The counter is aligned to the slow clock by releasing reset just after a slow rising edge. A small sequencer watches the counter and raises a one-cycle load strobe. On the third fast rising edge after the slow edge, that strobe copies each holding register into its channel's shift register. On every other fast edge the shift register moves left by one bit and fills the vacated bit with zero. The serial output is the most significant bit of the shift register, so D9 leaves first and D0 leaves last. The stream runs without gaps: the next word's D9 follows directly after the previous word's D0.

The sequencer has four states, and the phase counter keeps running through all of them:
- `ST_HOLD` is the state held while reset is high. It stands for phase 0.
- `ST_PRE` covers the phases before the load.
- `ST_LOAD` is the single phase in which the strobe is high.
- `ST_POST` covers the phases after the load.

The transitions are:
- Leave-reset: `ST_HOLD` to `ST_PRE`, or to `ST_LOAD` when the load phase is phase 1.
- Arm: `ST_PRE` to `ST_LOAD`, when the counter is one short of the load phase.
- Fire: `ST_LOAD` to `ST_POST`, or to `ST_PRE` when the load phase is the last one.
- Wrap: `ST_POST` to `ST_PRE`, when the counter is at its last value.

Any active-high reset returns the sequencer to `ST_HOLD`.

Top module: `par_serial_tx`

## Requirements
- R1: At each slow rising edge, channel c's holding register takes `par_in[c*WIDTH +: WIDTH]`. Changes to `par_in` between two slow edges do not alter the word that is transmitted.
- R2: The phase counter counts fast edges modulo `WIDTH`. It holds 0 after every fast edge with `rst` high, so releasing reset just after a slow rising edge makes the counter read 0 at each fast edge that coincides with a slow rising edge.
- R3: The load strobe is high for exactly one fast cycle per slow period. Its effect is to copy the holding register into the shift register on the third fast rising edge after a slow rising edge.
- R4: Bit `WIDTH-1` (D9) is sent first and bit 0 (D0) last, one bit per fast cycle. Between loads the shift register moves left and fills bit 0 with zero, and `ser_out[c]` is its most significant bit.
- R5: The serial stream has no gaps or repeated bits across word boundaries. A word captured at slow edge k drives its D9 after fast edge 3 of that period and its D0 after fast edge 2 of the next period. That is a fixed latency of 3 fast cycles from capture to first bit.
- R6: Each channel serializes only its own slice of `par_in`, with no interaction between channels.
- R7: `rst` is synchronous and active high. It clears the holding registers, the shift registers and the phase counter, and `ser_out` is 0 in the fast cycle after any fast edge sampled with `rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Bit clock, `WIDTH` times the slow rate |
| slow_clk | input | 1 | Word clock, rising edges coincide with fast rising edges |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| par_in | input | NUM_CH*WIDTH | Parallel words, channel c in bits `c*WIDTH +: WIDTH` |
| ser_out | output | NUM_CH | Serial output per channel, MSB first |

## Verification
Two things happen at the same fast edge: the slow rising edge that captures a new word into the holding register, and the fast shift that sends out a bit of the previous word. A second overlap is `par_in` changing while a load is pending. The bench provokes both by changing `par_in` one fast cycle after every slow edge, ahead of the load on the third edge. It then compares every serial bit, cycle by cycle, against a bench model that keeps the word captured at the current slow edge and the word captured at the one before. A single wrong bit at a boundary, a load on the wrong edge, or a word torn by the early input change shows up as a bit mismatch.

// File: rtl/pst_pkg.sv
`timescale 1ns/1ps
package pst_pkg;

    // Sequencer states of the load strobe generator
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // held in reset, phase 0
        ST_PRE  = 2'd1,   // phases before the load edge
        ST_LOAD = 2'd2,   // strobe active for one fast cycle
        ST_POST = 2'd3    // phases after the load edge
    } load_state_e;

endpackage

// File: rtl/pst_phase_counter.sv
`timescale 1ns/1ps
module pst_phase_counter #(
    parameter int WIDTH = 10,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] phase
);

    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // R2: counter returns to zero after its last value
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));

    // R2: counter advances by one on every other edge
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/pst_load_fsm.sv
`timescale 1ns/1ps
module pst_load_fsm
    import pst_pkg::*;
#(
    parameter int WIDTH     = 10,
    parameter int LOAD_EDGE = 3,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] phase,
    output logic          load_en
);

    localparam logic [CW-1:0] LAST     = CW'(WIDTH - 1);
    localparam logic [CW-1:0] ARM_PH   = CW'(LOAD_EDGE - 2);
    localparam logic [CW-1:0] LOAD_PH  = CW'(LOAD_EDGE - 1);
    localparam bit            LOAD_AT1 = (LOAD_EDGE == 2);
    localparam bit            LOAD_END = (LOAD_EDGE == WIDTH);

    load_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_HOLD;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: nxt = LOAD_AT1 ? ST_LOAD : ST_PRE;             // leave-reset
            ST_PRE:  nxt = (phase == ARM_PH) ? ST_LOAD : ST_PRE;    // arm
            ST_LOAD: nxt = LOAD_END ? ST_PRE : ST_POST;             // fire
            ST_POST: nxt = (phase == LAST) ? ST_PRE : ST_POST;      // wrap
            default: nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        load_en = 1'b0;
        unique case (state)
            ST_LOAD: load_en = 1'b1;
            ST_HOLD, ST_PRE, ST_POST: load_en = 1'b0;
            default: load_en = 1'b0;
        endcase
    end

    // R3: strobe only in the phase just before the third fast edge
    a_r3_load_phase: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (phase == LOAD_PH));

    // R3: strobe lasts a single fast cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !load_en);

endmodule

// File: rtl/pst_hold_reg.sv
`timescale 1ns/1ps
module pst_hold_reg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] hold
);

    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else
            hold <= din;
    end

    // R1: word seen at a slow edge is what the register holds afterwards
    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hold == $past(din)));

endmodule

// File: rtl/pst_shift_reg.sv
`timescale 1ns/1ps
module pst_shift_reg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] hold,
    output logic             ser
);

    logic [WIDTH-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (load_en)
            sreg <= hold;
        else
            sreg <= {sreg[WIDTH-2:0], 1'b0};
    end

    assign ser = sreg[WIDTH-1];

    // R3: a strobe moves the holding word into the shifter
    a_r3_copy: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (sreg == $past(hold)));

    // R4: without a strobe the shifter moves left, zero fill
    a_r4_shift_left: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (sreg == {$past(sreg[WIDTH-2:0]), 1'b0}));

endmodule

// File: rtl/par_serial_tx.sv
`timescale 1ns/1ps
module par_serial_tx #(
    parameter int WIDTH     = 10,
    parameter int LOAD_EDGE = 3,
    parameter int NUM_CH    = 2
) (
    input  logic                    fast_clk,
    input  logic                    slow_clk,
    input  logic                    rst,
    input  logic [NUM_CH*WIDTH-1:0] par_in,
    output logic [NUM_CH-1:0]       ser_out
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [CW-1:0] phase;
    logic          load_en;

    pst_phase_counter #(.WIDTH(WIDTH)) u_phase (
        .clk   (fast_clk),
        .rst   (rst),
        .phase (phase)
    );

    pst_load_fsm #(.WIDTH(WIDTH), .LOAD_EDGE(LOAD_EDGE)) u_fsm (
        .clk     (fast_clk),
        .rst     (rst),
        .phase   (phase),
        .load_en (load_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WIDTH-1:0] hold;

        pst_hold_reg #(.WIDTH(WIDTH)) u_hold (
            .clk  (slow_clk),
            .rst  (rst),
            .din  (par_in[c*WIDTH +: WIDTH]),
            .hold (hold)
        );

        pst_shift_reg #(.WIDTH(WIDTH)) u_shift (
            .clk     (fast_clk),
            .rst     (rst),
            .load_en (load_en),
            .hold    (hold),
            .ser     (ser_out[c])
        );
    end

endmodule

// File: tb/par_serial_tx_bench.sv
`timescale 1ns/1ps
module par_serial_tx_bench;

    localparam int W  = 10;
    localparam int LE = 3;
    localparam int NC = 2;

    logic              fast_clk = 1'b0;
    logic              slow_clk = 1'b0;
    logic              rst      = 1'b1;
    logic [NC*W-1:0]   par_in   = '0;
    logic [NC-1:0]     ser_out;

    int unsigned nchecks = 0;
    int unsigned nerr    = 0;
    int          ph      = W - 1;
    logic [W-1:0] cur_w  [NC];
    logic [W-1:0] prev_w [NC];
    logic         rst_edge = 1'b1;
    bit           finished = 1'b0;

    par_serial_tx #(.WIDTH(W), .LOAD_EDGE(LE), .NUM_CH(NC)) u_par_serial_tx (
        .fast_clk (fast_clk),
        .slow_clk (slow_clk),
        .rst      (rst),
        .par_in   (par_in),
        .ser_out  (ser_out)
    );

    initial begin
        for (int c = 0; c < NC; c++) begin
            cur_w[c]  = '0;
            prev_w[c] = '0;
        end
    end

    // 50 MHz fast clock; slow clock rises together with every W-th fast rise
    always begin
        #10;
        fast_clk = ~fast_clk;
        if (fast_clk) begin
            ph       = (ph == W - 1) ? 0 : ph + 1;
            rst_edge = rst;
            if (ph == 0) begin
                slow_clk = 1'b1;
                for (int c = 0; c < NC; c++) begin
                    prev_w[c] = cur_w[c];
                    cur_w[c]  = rst ? '0 : par_in[c*W +: W];
                end
            end else if (ph == W / 2) begin
                slow_clk = 1'b0;
            end
        end
    end

    function automatic logic exp_bit(input int c);
        if (rst_edge)
            return 1'b0;
        else if (ph >= LE)
            return cur_w[c][W - 1 - (ph - LE)];
        else
            return prev_w[c][LE - 1 - ph];
    endfunction

    function automatic string req_tag(input int c);
        string t;
        if (rst_edge)      t = "R7";
        else if (ph == 0)  t = "R2 R5";
        else if (ph < LE)  t = "R5";
        else if (ph == LE) t = "R1 R3";
        else               t = "R4";
        if (c > 0) t = {t, " R6"};
        return t;
    endfunction

    // Compare every serial bit of every channel between fast edges
    always @(negedge fast_clk) begin
        if (!finished) begin
            for (int c = 0; c < NC; c++) begin
                logic e;
                e = exp_bit(c);
                nchecks++;
                if (ser_out[c] !== e) begin
                    nerr++;
                    $display("FAIL %s ch%0d phase %0d: ser_out=%b expected=%b",
                             req_tag(c), c, ph, ser_out[c], e);
                end
            end
        end
    end

    task automatic wait_phase(input int p);
        do @(negedge fast_clk); while (ph != p);
    endtask

    // New words land one fast cycle after a slow edge, before the load edge
    task automatic send(input logic [W-1:0] w0, input logic [W-1:0] w1);
        wait_phase(1);
        par_in = {w1, w0};
    endtask

    task automatic do_reset(input int at_phase);
        wait_phase(at_phase);
        rst = 1'b1;
        repeat (3) wait_phase(0);
        rst = 1'b0;                  // release just after a slow edge (R2, R7)
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) wait_phase(0);
        rst = 1'b0;
        // directed corners: boundaries, MSB-only, LSB-only, alternation
        send(W'(10'h3FF), W'(10'h000));
        send(W'(10'h000), W'(10'h3FF));
        send(W'(10'h200), W'(10'h001));
        send(W'(10'h001), W'(10'h200));
        send(W'(10'h2AA), W'(10'h155));
        send(W'(10'h155), W'(10'h2AA));
        send(W'(10'h3FF), W'(10'h3FF));
        send(W'(10'h000), W'(10'h000));
        for (int i = 0; i < 120; i++)
            send(W'($urandom), W'($urandom));
        // reset in the middle of a word, after the load edge
        do_reset(5);
        send(W'(10'h3FE), W'(10'h17F));
        for (int i = 0; i < 120; i++)
            send(W'($urandom), W'($urandom));
        // reset just before the load edge
        do_reset(2);
        for (int i = 0; i < 40; i++)
            send(W'($urandom), W'($urandom));
        repeat (3) wait_phase(0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            nerr++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

endmodule